// File: doc/BRIEF.md
# Register-Exchange Survivor Memory

This block keeps the survivor paths of a Viterbi decoder. It uses the register-exchange method. Every trellis state owns a shift register as long as the survivor window, and that register holds the decoded bit history of the state's surviving path. An add-compare-select array sits upstream and produces one decision bit per state on each trellis step. On each step, every state takes a copy of the history owned by the predecessor its decision picks. It moves that copy one place toward the old end and adds its own input bit at the new end.

Decoded bits come from the old end of the register that belongs to state 0. The window is made long enough for all paths to merge, so that bit is the same whichever state it is read from. No trace-back pass is needed. Output latency is fixed: one decoded bit appears for each accepted step once the window has filled. Path metrics, their normalisation and the choice of a best state all belong to the upstream logic.

Top module: `rx_survivor_unit`

## Requirements
- R1: A rising edge with rst_n low clears every per-state register and the output valid. From the next cycle, bit_out and bit_vld read 0.
- R2: After reset, bit_vld stays 0 through the first SURV_LEN-1 accepted steps. It first goes high in the cycle that follows the edge accepting step number SURV_LEN.
- R3: Once SURV_LEN steps have been accepted, bit_vld is high for exactly the cycle after each edge where dec_vld was high. It is low after every edge where dec_vld was low.
- R4: On an accepted step, state S takes the register of its predecessor P = dec_bits[S]·(NUM_STATES/2) + floor(S/2). That copy moves one position toward the oldest end, P's oldest bit is discarded, and bit 0 of S enters position 0 (the newest position).
- R5: bit_out is position SURV_LEN-1 of state 0's register. After step n (n ≥ SURV_LEN), it equals bit 0 of the state reached as follows: start at state 0 and take SURV_LEN-1 predecessor steps using the decision vectors of steps n, n-1, …, n-SURV_LEN+2.
- R6: An edge with dec_vld low changes no per-state register, so bit_out keeps its value.
- R7: Bit S of dec_bits is the decision of state S (bit 0 belongs to state 0). A vector with a single bit set changes the predecessor of that state only.
- R8: The defaults are 8 states and a survivor length of 15 (five times log2 of the state count). NUM_STATES must be a power of two and at least 2, and SURV_LEN at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_vld | input | 1 | High when dec_bits holds a new trellis step |
| dec_bits | input | NUM_STATES | One survivor decision per state, bit S for state S |
| bit_out | output | 1 | Decoded bit, the oldest entry of state 0's history |
| bit_vld | output | 1 | One-cycle pulse marking a fresh decoded bit |

## Verification
The assertions expect dec_vld to be a known level at every edge after reset. They also expect reset to be held for at least one rising edge, so the step count seen by the checker starts from zero together with the design. They make no claim about the decision values, because any vector is a legal trellis step. The bench changes inputs only on falling edges and keeps dec_vld low whenever it is not presenting a step. Its decision vectors are all-zero, all-one, single-bit and pseudo-random, and they come with idle gaps and a reset in the middle of a run.

// File: rtl/rx_survivor_pkg.sv
// Package: shared defaults and trellis helper functions for the survivor unit.
// Assumes a shift-register trellis in which the state index moves left by
// one place per step and the new input bit enters at bit 0.
package rx_survivor_pkg;

    localparam int unsigned DEFAULT_STATES = 8;
    localparam int unsigned DEFAULT_SURV   = 15;

    // Index of the predecessor that a state's decision selects.
    function automatic int unsigned pred_state(input int unsigned state,
                                               input int unsigned n_states,
                                               input bit          dec);
        return (dec ? (n_states / 2) : 0) + (state / 2);
    endfunction

    // Input bit that drove the transition into a state.
    function automatic bit entry_bit(input int unsigned state);
        return bit'(state % 2);
    endfunction

endpackage

// File: rtl/rx_state_cell.sv
// Module: one state's survivor history register.
// On a step it copies one of two candidate histories (lower or upper
// predecessor), shifts the copy toward the oldest end and writes the state's
// own entry bit at position 0. Assumes SURV_LEN >= 2.
module rx_state_cell #(
    parameter int unsigned SURV_LEN  = 15,
    parameter bit          ENTRY_BIT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                pick_upper,
    input  logic [SURV_LEN-1:0] cand_lower,
    input  logic [SURV_LEN-1:0] cand_upper,
    output logic [SURV_LEN-1:0] surv_q
);

    logic [SURV_LEN-1:0] chosen;

    // Select the predecessor history named by this state's decision.
    always_comb begin
        chosen = pick_upper ? cand_upper : cand_lower;
    end

    // Shift in the entry bit; the oldest bit of the copy falls off the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            surv_q <= '0;
        end else if (step) begin
            surv_q <= SURV_LEN'({chosen, ENTRY_BIT});
        end
    end

endmodule

// File: rtl/rx_fill_ctr.sv
// Module: saturating count of accepted steps since reset.
// ripe goes high once LIMIT-1 steps are in, so the step now presented
// completes the window. Assumes LIMIT >= 2.
module rx_fill_ctr #(
    parameter int unsigned LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic ripe
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] PRE  = CW'(LIMIT - 1);

    logic [CW-1:0] count_q;

    // Count accepted steps and stop at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step && (count_q != TOP)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Window complete after the step now offered.
    always_comb begin
        ripe = (count_q >= PRE);
    end

endmodule

// File: rtl/rx_survivor_unit.sv
// Module: register-exchange survivor memory (top).
// Holds one SURV_LEN-bit history per trellis state. On each accepted step,
// every state copies its chosen predecessor's history in the same edge. The
// decoded bit is the oldest entry of state 0. Assumes NUM_STATES is a power
// of two >= 2, SURV_LEN >= 2, and one decision vector per accepted step.
module rx_survivor_unit #(
    parameter int unsigned NUM_STATES = rx_survivor_pkg::DEFAULT_STATES,
    parameter int unsigned SURV_LEN   = rx_survivor_pkg::DEFAULT_SURV
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_vld,
    input  logic [NUM_STATES-1:0] dec_bits,
    output logic                  bit_out,
    output logic                  bit_vld
);

    logic [SURV_LEN-1:0] surv_q [NUM_STATES];
    logic                ripe;
    logic                vld_q;

    // One history register per state, wired to its two possible predecessors.
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
        localparam int unsigned LOWER =
            rx_survivor_pkg::pred_state(s, NUM_STATES, 1'b0);
        localparam int unsigned UPPER =
            rx_survivor_pkg::pred_state(s, NUM_STATES, 1'b1);

        rx_state_cell #(
            .SURV_LEN  (SURV_LEN),
            .ENTRY_BIT (rx_survivor_pkg::entry_bit(s))
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .step       (dec_vld),
            .pick_upper (dec_bits[s]),
            .cand_lower (surv_q[LOWER]),
            .cand_upper (surv_q[UPPER]),
            .surv_q     (surv_q[s])
        );
    end

    rx_fill_ctr #(
        .LIMIT (SURV_LEN)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (dec_vld),
        .ripe  (ripe)
    );

    // Flag a fresh decoded bit after each step once the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= dec_vld & ripe;
        end
    end

    assign bit_out = surv_q[0][SURV_LEN-1];
    assign bit_vld = vld_q;

endmodule

// File: rtl/rx_survivor_chk.sv
// Module: protocol checker for rx_survivor_unit, bound to every instance.
// Keeps its own count of accepted steps and checks output timing against it.
// Assumes dec_vld is a known level at every edge after reset.
module rx_survivor_chk #(
    parameter int unsigned SURV_LEN = 15
) (
    input logic clk,
    input logic rst_n,
    input logic dec_vld,
    input logic bit_vld,
    input logic bit_out
);

    localparam int unsigned CW = $clog2(SURV_LEN + 1);
    localparam logic [CW-1:0] SAT = CW'(SURV_LEN);
    localparam logic [CW-1:0] PRE = CW'(SURV_LEN - 1);

    logic [CW-1:0] seen_q;

    // Independent saturating step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (dec_vld && (seen_q != SAT)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R1: outputs are clear on the first cycle out of reset.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!bit_vld && !bit_out));

    // R2: no valid before the window has filled.
    p_no_early_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> (seen_q == SAT));

    // R3: a valid pulse always follows an accepted step.
    p_valid_needs_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(dec_vld));

    // R3: every accepted step after fill yields a valid pulse.
    p_valid_after_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && (seen_q >= PRE)) |=> bit_vld);

    // R6: an idle edge leaves the decoded bit unchanged.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dec_vld)) |-> $stable(bit_out));

endmodule

bind rx_survivor_unit rx_survivor_chk #(
    .SURV_LEN (SURV_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_vld (dec_vld),
    .bit_vld (bit_vld),
    .bit_out (bit_out)
);

// File: tb/rx_survivor_unit_tb.sv
// Bench: directed scenarios for rx_survivor_unit at its default parameters.
// Expected bits come from a trace-back over the recorded decision history.
module rx_survivor_unit_tb;

    localparam int NS = 8;
    localparam int L  = 15;
    localparam int K  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_vld = 1'b0;
    logic [NS-1:0] dec_bits = '0;
    logic          bit_out;
    logic          bit_vld;

    int n_checks = 0;
    int n_fail   = 0;
    int n_step   = 0;
    bit done     = 1'b0;
    logic [NS-1:0] hist [0:1023];
    logic [15:0]   lfsr = 16'hACE1;

    rx_survivor_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_vld  (dec_vld),
        .dec_bits (dec_bits),
        .bit_out  (bit_out),
        .bit_vld  (bit_vld)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
    endtask

    function automatic logic [NS-1:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[NS-1:0] ^ lfsr[15:8];
    endfunction

    // Trace back from state 0 over L-1 steps ending at step n (R5 model).
    function automatic logic model_bit(input int n);
        int s = 0;
        for (int j = 0; j < L - 1; j++) begin
            logic d;
            d = hist[n - j][s];
            s = (s >> 1) | (int'(d) << (K - 1));
        end
        return logic'(s & 1);
    endfunction

    // Present one step, then check outputs after the capturing edge.
    task automatic do_step(input logic [NS-1:0] d, input string req);
        dec_vld  = 1'b1;
        dec_bits = d;
        n_step++;
        hist[n_step] = d;
        @(negedge clk);
        dec_vld = 1'b0;
        if (n_step >= L) begin
            logic e;
            e = model_bit(n_step);
            check(bit_vld === 1'b1, "R3", "valid after filled step", bit_vld, 1'b1);
            check(bit_out === e, req, "decoded bit", bit_out, e);
        end else begin
            check(bit_vld === 1'b0, "R2", "valid before window full", bit_vld, 1'b0);
        end
    endtask

    task automatic do_idle();
        logic prev;
        prev = bit_out;
        dec_vld = 1'b0;
        @(negedge clk);
        check(bit_vld === 1'b0, "R3", "valid after idle edge", bit_vld, 1'b0);
        check(bit_out === prev, "R6", "bit held on idle edge", bit_out, prev);
    endtask

    task automatic apply_reset();
        rst_n   = 1'b0;
        dec_vld = 1'b0;
        repeat (2) @(negedge clk);
        check(bit_vld === 1'b0, "R1", "valid in reset", bit_vld, 1'b0);
        check(bit_out === 1'b0, "R1", "bit in reset", bit_out, 1'b0);
        rst_n  = 1'b1;
        n_step = 0;
        @(negedge clk);
        check(bit_vld === 1'b0, "R1", "valid after reset", bit_vld, 1'b0);
        check(bit_out === 1'b0, "R1", "bit after reset", bit_out, 1'b0);
    endtask

    // R2, R8: valid first appears on step 15 at default size.
    task automatic t_fill_window();
        for (int i = 0; i < L; i++) do_step(next_rand(), "R8");
    endtask

    // R4, R5: fixed patterns.
    task automatic t_fixed_patterns();
        for (int i = 0; i < 20; i++) do_step('0, "R4");
        for (int i = 0; i < 20; i++) do_step('1, "R4");
        for (int i = 0; i < 20; i++) do_step(NS'(8'h55 << (i % 2)), "R5");
    endtask

    // R7: one decision bit at a time moves only that state's predecessor.
    task automatic t_single_bits();
        for (int i = 0; i < 48; i++) do_step(NS'(1) << ((i / 3) % NS), "R7");
    endtask

    // R5: pseudo-random decisions.
    task automatic t_random();
        for (int i = 0; i < 120; i++) do_step(next_rand(), "R5");
    endtask

    // R3, R6: steps broken by idle cycles.
    task automatic t_gaps();
        for (int i = 0; i < 30; i++) begin
            do_step(next_rand(), "R5");
            for (int g = 0; g < (i % 3) + 1; g++) do_idle();
        end
    endtask

    // R1, R2: reset in the middle of a run restarts the window.
    task automatic t_mid_reset();
        for (int i = 0; i < 10; i++) do_step('1, "R5");
        apply_reset();
        for (int i = 0; i < L + 5; i++) do_step(next_rand(), "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        apply_reset();
        t_fill_window();
        t_fixed_patterns();
        t_single_bits();
        t_random();
        t_gaps();
        t_mid_reset();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule